// File: doc/BRIEF.md
# Block-Check Unit Register Front End

This block is the programmed-I/O register front end for a bank of up to eight block-check engines that share one 16-bit bus. It raises no interrupts. Each bus access carries a 6-bit address. The upper three bits pick a unit and the next two bits pick one of that unit's registers: a control/status word, the block-check result, or a data word. For byte accesses, bit 0 picks the byte lane. The block merges byte writes into the current register value. It stores only the writable control fields and turns two write-one bits into single-cycle strobes toward the engine. Writing a data word starts a full computation when shift mode is enabled.

The arithmetic is left to a neighbouring engine per unit. The front end drives that engine with start, step and clear pulses, the stored 4-bit configuration and the data word. It receives back the result, the quotient bit and a finish pulse. The front end owns the done flag and a busy indication, so software polls the status word and treats the result as valid only once done reads as 1. A unit whose enable input is low, or whose index is not below the unit count, answers every access as nonexistent and changes no state.

Top module: `blkchk_regif`

## Requirements
- R1: Address bits [5:3] select the unit and bits [2:1] select the register: 0 status, 1 result, 2 data. Register code 3 reads as zero and ignores writes.
- R2: An access to a unit whose index is not below NUM_UNITS, or whose `unit_en` bit is 0, answers with `rsp_nxm`=1 and `rsp_rdata`=0. It changes no stored value and issues no engine pulse.
- R3: A status read returns the quotient bit (`eng_quo` of the unit) at bit 8, done at bit 7, shift enable at bit 6, and the 4-bit configuration at bits [3:0]. All other bits read 0, including the two strobe bits 5 and 4.
- R4: A status write stores only bit 6 (shift enable) and bits [3:0] (configuration). Any value written to bits 7 and 8 has no effect. The configuration appears on `eng_cfg`.
- R5: On a byte write (`bus_byte`=1) the byte travels in `bus_wdata[7:0]`. Address bit 0 = 1 replaces the high byte and bit 0 = 0 replaces the low byte of the status or data register. The other byte keeps its current value.
- R6: A status write with bit 4 set gives one `eng_clear` pulse for that unit in the cycle after the write, sets done and drops busy.
- R7: A status write with bit 5 = 1, bit 6 = 0 and bit 4 = 0 to a unit whose done is 0 gives exactly one `eng_step` pulse in the next cycle. Any other status write gives no step.
- R8: A data write stores the 16-bit word on `eng_data` and clears done. If the stored shift enable is 1, it also gives one `eng_start` pulse in the next cycle and raises `unit_busy`.
- R9: An `eng_fin` pulse sets the unit's done flag and clears its busy indication.
- R10: A result read returns that unit's `eng_result`. Writes to the result register are ignored, and data register reads return 0.
- R11: After reset every unit has done = 1, configuration 0, shift enable 0, data 0 and busy 0. No response and no engine pulse is active.
- R12: Every request gets exactly one `rsp_valid` pulse, in the cycle after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_addr | input | 6 | Unit [5:3], register [2:1], byte lane [0] |
| bus_wdata | input | 16 | Write data (byte writes use bits [7:0]) |
| unit_en | input | NUM_UNITS | Per-unit present/enable |
| rsp_valid | output | 1 | Response strobe |
| rsp_nxm | output | 1 | Nonexistent-unit response |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| eng_start | output | NUM_UNITS | Full-computation start pulse per unit |
| eng_step | output | NUM_UNITS | Single-step pulse per unit |
| eng_clear | output | NUM_UNITS | Result/count clear pulse per unit |
| eng_cfg | output | NUM_UNITS*4 | Stored configuration per unit |
| eng_data | output | NUM_UNITS*16 | Stored data word per unit |
| eng_result | input | NUM_UNITS*16 | Block-check result per unit |
| eng_quo | input | NUM_UNITS | Quotient bit per unit |
| eng_fin | input | NUM_UNITS | Computation finished pulse per unit |
| unit_busy | output | NUM_UNITS | Computation in progress per unit |

## Verification
A request sampled at a rising edge produces its response fields and its engine pulses together, in the cycle that follows that edge. Register contents updated by the write, such as `eng_data` and `eng_cfg`, change at that same edge. Done changes at the edge that samples an `eng_fin` pulse. The bench drives every input at the falling edge and samples all outputs at the next falling edge, after the one capturing edge. It checks one falling edge later that each pulse and `rsp_valid` have dropped, and reads status back through the bus to observe done.

// File: rtl/blkchk_regif_pkg.sv
package blkchk_regif_pkg;

  localparam int WORD_W   = 16;
  localparam int CFG_W    = 4;
  localparam int BIT_SEN  = 6;
  localparam int BIT_STEP = 5;
  localparam int BIT_CLR  = 4;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_RES  = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/blkchk_addr_dec.sv
module blkchk_addr_dec
  import blkchk_regif_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int UNIT_AW   = 3
) (
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [UNIT_AW+1:0]   addr_hi,
  input  logic [NUM_UNITS-1:0] unit_en,
  output logic                 hit,
  output logic                 nxm,
  output logic [UNIT_AW-1:0]   unit_idx,
  output reg_sel_e             reg_sel,
  output logic [NUM_UNITS-1:0] wr_stat,
  output logic [NUM_UNITS-1:0] wr_data
);

  localparam logic [UNIT_AW:0] UNIT_LIM = (UNIT_AW+1)'(NUM_UNITS);

  logic in_range;
  logic en_bit;

  assign unit_idx = addr_hi[UNIT_AW+1:2];
  assign reg_sel  = reg_sel_e'(addr_hi[1:0]);
  assign in_range = {1'b0, unit_idx} < UNIT_LIM;

  always_comb begin
    en_bit = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_idx == UNIT_AW'(u)) en_bit = unit_en[u];
    end
  end

  assign hit = bus_req && in_range && en_bit;
  assign nxm = bus_req && !hit;

  always_comb begin
    wr_stat = '0;
    wr_data = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (hit && bus_we && unit_idx == UNIT_AW'(u)) begin
        wr_stat[u] = (reg_sel == REG_STAT);
        wr_data[u] = (reg_sel == REG_DATA);
      end
    end
  end

endmodule

// File: rtl/blkchk_unit_ctl.sv
module blkchk_unit_ctl
  import blkchk_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic              wr_data,
  input  logic              wr_byte,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              eng_fin,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              sen_q,
  output logic              done_q,
  output logic [WORD_W-1:0] data_q,
  output logic              start_q,
  output logic              step_q,
  output logic              clear_q,
  output logic              busy_q
);

  logic [CFG_W-1:0]  cfg_d;
  logic              sen_d, done_d, busy_d;
  logic [WORD_W-1:0] data_d;
  logic              start_d, step_d, clear_d;
  logic [6:0]        stat_lo;
  logic [WORD_W-1:0] data_wr;
  logic              state_en;

  // Only the low byte of the status word holds writable fields
  assign stat_lo = (wr_byte && wr_hi) ? {sen_q, 2'b00, cfg_q} : wdata[6:0];

  always_comb begin
    if (!wr_byte)   data_wr = wdata;
    else if (wr_hi) data_wr = {wdata[7:0], data_q[7:0]};
    else            data_wr = {data_q[WORD_W-1:8], wdata[7:0]};
  end

  assign state_en = wr_stat || wr_data || eng_fin;

  always_comb begin
    cfg_d   = cfg_q;
    sen_d   = sen_q;
    done_d  = done_q;
    busy_d  = busy_q;
    data_d  = data_q;
    start_d = 1'b0;
    step_d  = 1'b0;
    clear_d = 1'b0;
    if (eng_fin) begin
      done_d = 1'b1;
      busy_d = 1'b0;
    end
    if (wr_stat) begin
      sen_d = stat_lo[BIT_SEN];
      cfg_d = stat_lo[CFG_W-1:0];
      if (stat_lo[BIT_CLR]) begin
        done_d  = 1'b1;
        busy_d  = 1'b0;
        clear_d = 1'b1;
      end else if (stat_lo[BIT_STEP] && !stat_lo[BIT_SEN] && !done_d) begin
        step_d = 1'b1;
      end
    end
    if (wr_data) begin
      data_d = data_wr;
      done_d = 1'b0;
      if (sen_q) begin
        start_d = 1'b1;
        busy_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sen_q  <= 1'b0;
      done_q <= 1'b1;
      busy_q <= 1'b0;
      data_q <= '0;
    end else if (state_en) begin
      cfg_q  <= cfg_d;
      sen_q  <= sen_d;
      done_q <= done_d;
      busy_q <= busy_d;
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      step_q  <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      start_q <= start_d;
      step_q  <= step_d;
      clear_q <= clear_d;
    end
  end

endmodule

// File: rtl/blkchk_rd_mux.sv
module blkchk_rd_mux
  import blkchk_regif_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int UNIT_AW   = 3
) (
  input  logic [UNIT_AW-1:0]                  unit_idx,
  input  reg_sel_e                            reg_sel,
  input  logic [NUM_UNITS-1:0][CFG_W-1:0]     cfg_arr,
  input  logic [NUM_UNITS-1:0]                sen_vec,
  input  logic [NUM_UNITS-1:0]                done_vec,
  input  logic [NUM_UNITS-1:0]                quo_vec,
  input  logic [NUM_UNITS-1:0][WORD_W-1:0]    res_arr,
  output logic [WORD_W-1:0]                   rd_val
);

  logic [WORD_W-1:0] stat_w;
  logic [WORD_W-1:0] res_w;

  always_comb begin
    stat_w = '0;
    res_w  = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_idx == UNIT_AW'(u)) begin
        stat_w = {7'b0, quo_vec[u], done_vec[u], sen_vec[u], 2'b00, cfg_arr[u]};
        res_w  = res_arr[u];
      end
    end
  end

  always_comb begin
    case (reg_sel)
      REG_STAT: rd_val = stat_w;
      REG_RES:  rd_val = res_w;
      default:  rd_val = '0;
    endcase
  end

endmodule

// File: rtl/blkchk_regif.sv
module blkchk_regif
  import blkchk_regif_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int UNIT_AW   = 3,
  localparam int ADDR_W   = UNIT_AW + 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_req,
  input  logic                        bus_we,
  input  logic                        bus_byte,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  input  logic [NUM_UNITS-1:0]        unit_en,
  output logic                        rsp_valid,
  output logic                        rsp_nxm,
  output logic [WORD_W-1:0]           rsp_rdata,
  output logic [NUM_UNITS-1:0]        eng_start,
  output logic [NUM_UNITS-1:0]        eng_step,
  output logic [NUM_UNITS-1:0]        eng_clear,
  output logic [NUM_UNITS*CFG_W-1:0]  eng_cfg,
  output logic [NUM_UNITS*WORD_W-1:0] eng_data,
  input  logic [NUM_UNITS*WORD_W-1:0] eng_result,
  input  logic [NUM_UNITS-1:0]        eng_quo,
  input  logic [NUM_UNITS-1:0]        eng_fin,
  output logic [NUM_UNITS-1:0]        unit_busy
);

  logic                             hit, nxm;
  logic [UNIT_AW-1:0]               unit_idx;
  reg_sel_e                         reg_sel;
  logic [NUM_UNITS-1:0]             wr_stat, wr_data;
  logic [NUM_UNITS-1:0][CFG_W-1:0]  cfg_arr;
  logic [NUM_UNITS-1:0]             sen_vec, done_vec;
  logic [NUM_UNITS-1:0][WORD_W-1:0] data_arr, res_arr;
  logic [WORD_W-1:0]                rd_val;
  logic                             rsp_valid_d, rsp_nxm_d;
  logic [WORD_W-1:0]                rsp_rdata_d;

  blkchk_addr_dec #(.NUM_UNITS(NUM_UNITS), .UNIT_AW(UNIT_AW)) dec_i (
    .bus_req (bus_req),
    .bus_we  (bus_we),
    .addr_hi (bus_addr[ADDR_W-1:1]),
    .unit_en (unit_en),
    .hit     (hit),
    .nxm     (nxm),
    .unit_idx(unit_idx),
    .reg_sel (reg_sel),
    .wr_stat (wr_stat),
    .wr_data (wr_data)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    blkchk_unit_ctl unit_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stat(wr_stat[u]),
      .wr_data(wr_data[u]),
      .wr_byte(bus_byte),
      .wr_hi  (bus_addr[0]),
      .wdata  (bus_wdata),
      .eng_fin(eng_fin[u]),
      .cfg_q  (cfg_arr[u]),
      .sen_q  (sen_vec[u]),
      .done_q (done_vec[u]),
      .data_q (data_arr[u]),
      .start_q(eng_start[u]),
      .step_q (eng_step[u]),
      .clear_q(eng_clear[u]),
      .busy_q (unit_busy[u])
    );
    assign eng_cfg[u*CFG_W +: CFG_W]    = cfg_arr[u];
    assign eng_data[u*WORD_W +: WORD_W] = data_arr[u];
    assign res_arr[u]                   = eng_result[u*WORD_W +: WORD_W];
  end

  blkchk_rd_mux #(.NUM_UNITS(NUM_UNITS), .UNIT_AW(UNIT_AW)) mux_i (
    .unit_idx(unit_idx),
    .reg_sel (reg_sel),
    .cfg_arr (cfg_arr),
    .sen_vec (sen_vec),
    .done_vec(done_vec),
    .quo_vec (eng_quo),
    .res_arr (res_arr),
    .rd_val  (rd_val)
  );

  always_comb begin
    rsp_valid_d = bus_req;
    rsp_nxm_d   = nxm;
    rsp_rdata_d = (hit && !bus_we) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_nxm   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_nxm   <= rsp_nxm_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

endmodule

// File: rtl/blkchk_regif_chk.sv
module blkchk_regif_chk #(
  parameter int NUM_UNITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_req,
  input logic                 rsp_valid,
  input logic                 rsp_nxm,
  input logic [NUM_UNITS-1:0] eng_start,
  input logic [NUM_UNITS-1:0] eng_step,
  input logic [NUM_UNITS-1:0] eng_clear,
  input logic [NUM_UNITS-1:0] eng_fin,
  input logic [NUM_UNITS-1:0] unit_busy,
  input logic [NUM_UNITS-1:0] done_vec
);

  a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> rsp_valid);

  a_r12_rsp_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_req));

  a_r2_nxm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nxm |-> (eng_start == '0 && eng_step == '0 && eng_clear == '0));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start, eng_step, eng_clear}));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
    a_r7_step_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      eng_step[u] |-> !$past(done_vec[u]));

    a_r6_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
      eng_clear[u] |-> (done_vec[u] && !unit_busy[u]));

    a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start[u] |-> (unit_busy[u] && !done_vec[u]));

    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_vec[u]) |-> ($past(eng_fin[u]) || eng_clear[u]));
  end

endmodule

bind blkchk_regif blkchk_regif_chk #(.NUM_UNITS(NUM_UNITS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .rsp_valid(rsp_valid),
  .rsp_nxm  (rsp_nxm),
  .eng_start(eng_start),
  .eng_step (eng_step),
  .eng_clear(eng_clear),
  .eng_fin  (eng_fin),
  .unit_busy(unit_busy),
  .done_vec (done_vec)
);

// File: tb/blkchk_regif_tb_top.sv
`timescale 1ns/100ps
module blkchk_regif_tb_top;

  localparam int NU = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_req, bus_we, bus_byte;
  logic [5:0]    bus_addr;
  logic [15:0]   bus_wdata;
  logic [NU-1:0] unit_en;
  logic          rsp_valid, rsp_nxm;
  logic [15:0]   rsp_rdata;
  logic [NU-1:0] eng_start, eng_step, eng_clear, eng_quo, eng_fin, unit_busy;
  logic [NU*4-1:0]  eng_cfg;
  logic [NU*16-1:0] eng_data, eng_result;

  int n_cmp = 0;
  int n_bad = 0;

  logic          g_valid, g_nxm;
  logic [15:0]   g_rdata;
  logic [NU-1:0] g_start, g_step, g_clear, g_busy;

  always #2.5 clk = ~clk;

  blkchk_regif #(.NUM_UNITS(NU), .UNIT_AW(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_byte(bus_byte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .unit_en(unit_en), .rsp_valid(rsp_valid), .rsp_nxm(rsp_nxm),
    .rsp_rdata(rsp_rdata), .eng_start(eng_start), .eng_step(eng_step),
    .eng_clear(eng_clear), .eng_cfg(eng_cfg), .eng_data(eng_data),
    .eng_result(eng_result), .eng_quo(eng_quo), .eng_fin(eng_fin),
    .unit_busy(unit_busy)
  );

  // {we, byte, addr[5:0], wdata[15:0], exp_nxm, exp_rdata[15:0]}
  localparam logic [40:0] VEC [18] = '{
    {1'b0, 1'b0, 6'h00, 16'h0000, 1'b0, 16'h0080},
    {1'b1, 1'b0, 6'h00, 16'h004B, 1'b0, 16'h0000},
    {1'b0, 1'b0, 6'h00, 16'h0000, 1'b0, 16'h00CB},
    {1'b1, 1'b0, 6'h00, 16'hFFFF, 1'b0, 16'h0000},
    {1'b0, 1'b0, 6'h00, 16'h0000, 1'b0, 16'h00CF},
    {1'b1, 1'b1, 6'h08, 16'h0005, 1'b0, 16'h0000},
    {1'b0, 1'b0, 6'h08, 16'h0000, 1'b0, 16'h0085},
    {1'b1, 1'b1, 6'h09, 16'h00FF, 1'b0, 16'h0000},
    {1'b0, 1'b0, 6'h08, 16'h0000, 1'b0, 16'h0085},
    {1'b0, 1'b0, 6'h10, 16'h0000, 1'b0, 16'h0180},
    {1'b0, 1'b0, 6'h12, 16'h0000, 1'b0, 16'hA002},
    {1'b1, 1'b0, 6'h12, 16'h1234, 1'b0, 16'h0000},
    {1'b1, 1'b0, 6'h1C, 16'hBEEF, 1'b0, 16'h0000},
    {1'b0, 1'b0, 6'h1C, 16'h0000, 1'b0, 16'h0000},
    {1'b0, 1'b0, 6'h18, 16'h0000, 1'b0, 16'h0000},
    {1'b0, 1'b0, 6'h38, 16'h0000, 1'b1, 16'h0000},
    {1'b0, 1'b0, 6'h1E, 16'h0000, 1'b0, 16'h0000},
    {1'b1, 1'b0, 6'h3C, 16'h5555, 1'b1, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the capture edge
  task automatic acc(input logic we, input logic byt, input logic [5:0] a, input logic [15:0] d);
    bus_req = 1'b1; bus_we = we; bus_byte = byt; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
    g_valid = rsp_valid; g_nxm = rsp_nxm; g_rdata = rsp_rdata;
    g_start = eng_start; g_step = eng_step; g_clear = eng_clear; g_busy = unit_busy;
  endtask

  task automatic fin(input int u);
    eng_fin[u] = 1'b1;
    @(negedge clk);
    eng_fin = '0;
  endtask

  function automatic logic [5:0] ad(input int u, input int r, input int odd);
    return {3'(u), 2'(r), 1'(odd)};
  endfunction

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
    bus_addr = '0; bus_wdata = '0; unit_en = 8'h7F;
    eng_quo = 8'h04; eng_fin = '0;
    for (int u = 0; u < NU; u++) eng_result[u*16 +: 16] = 16'hA000 + 16'(u);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 rsp_valid", 32'(rsp_valid), 0);
    chk("R11 unit_busy", 32'(unit_busy), 0);
    chk("R11 pulses", 32'({eng_start, eng_step, eng_clear}), 0);
    chk("R11 eng_cfg", eng_cfg, 0);
    chk("R11 eng_data low units", eng_data[63:0] == 64'h0 ? 32'd1 : 32'd0, 1);

    // Vector table: R1 R3 R4 R5 R10 R2
    for (int i = 0; i < 18; i++) begin
      acc(VEC[i][40], VEC[i][39], VEC[i][38:33], VEC[i][32:17]);
      chk($sformatf("R1/R3/R4/R10 vec %0d rdata", i), 32'(g_rdata), 32'(VEC[i][15:0]));
      chk($sformatf("R2 vec %0d nxm", i), 32'(g_nxm), 32'(VEC[i][16]));
      chk($sformatf("R12 vec %0d valid", i), 32'(g_valid), 1);
    end

    // R5 data byte merge on unit 4 (shift enable 0, so no start)
    acc(1, 0, ad(4, 2, 0), 16'h1234);
    chk("R8 data stored", 32'(eng_data[4*16 +: 16]), 32'h1234);
    chk("R8 no start without shift enable", 32'(g_start), 0);
    acc(1, 1, ad(4, 2, 1), 16'h00AB);
    chk("R5 high byte", 32'(eng_data[4*16 +: 16]), 32'hAB34);
    acc(1, 1, ad(4, 2, 0), 16'h00CD);
    chk("R5 low byte", 32'(eng_data[4*16 +: 16]), 32'hABCD);
    chk("R4 cfg unit1", 32'(eng_cfg[1*4 +: 4]), 32'h5);

    // R8 start on data write with shift enable
    acc(1, 0, ad(5, 0, 0), 16'h0040);
    acc(1, 0, ad(5, 2, 0), 16'h00FF);
    chk("R8 start pulse", 32'(g_start), 32'h20);
    chk("R8 busy", 32'(g_busy[5]), 1);
    @(negedge clk);
    chk("R8 start single", 32'(eng_start), 0);
    chk("R12 valid single", 32'(rsp_valid), 0);
    acc(0, 0, ad(5, 0, 0), 16'h0);
    chk("R8 done cleared", 32'(g_rdata), 32'h0040);
    fin(5);
    acc(0, 0, ad(5, 0, 0), 16'h0);
    chk("R9 done set", 32'(g_rdata), 32'h00C0);
    chk("R9 busy cleared", 32'(unit_busy[5]), 0);

    // R7 stepping on unit 6
    acc(1, 0, ad(6, 0, 0), 16'h0000);
    acc(1, 0, ad(6, 2, 0), 16'h0001);
    chk("R7 no start", 32'(g_start), 0);
    acc(1, 0, ad(6, 0, 0), 16'h0020);
    chk("R7 step pulse", 32'(g_step), 32'h40);
    acc(1, 0, ad(6, 0, 0), 16'h0060);
    chk("R7 no step with shift enable", 32'(g_step), 0);
    fin(6);
    acc(1, 0, ad(6, 0, 0), 16'h0020);
    chk("R7 no step when done", 32'(g_step), 0);

    // R6 clear
    acc(1, 0, ad(6, 2, 0), 16'h0002);
    acc(1, 0, ad(6, 0, 0), 16'h0030);
    chk("R6 clear pulse", 32'(g_clear), 32'h40);
    chk("R6 clear wins over step", 32'(g_step), 0);
    acc(0, 0, ad(6, 0, 0), 16'h0);
    chk("R6 done after clear", 32'(g_rdata), 32'h0080);

    // R2 disabled unit leaves state untouched, then enable it
    acc(1, 0, ad(7, 0, 0), 16'h0010);
    chk("R2 no pulse", 32'({g_start, g_step, g_clear}), 0);
    chk("R2 data untouched", 32'(eng_data[7*16 +: 16]), 0);
    unit_en = 8'hFF;
    acc(0, 0, ad(7, 0, 0), 16'h0);
    chk("R2 enabled nxm", 32'(g_nxm), 0);
    chk("R2 enabled status", 32'(g_rdata), 32'h0080);

    summary();
  end

endmodule